// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block recovers a single low-speed USB packet from the differential line pair. The system clock runs at roughly eleven times the bit rate. The receiver is armed by a one-cycle `start` pulse. It then watches the idle bus for the J-to-K transitions of the sync pattern and locks its bit-phase counter to the last of them. After that it samples each bit near its centre, decodes NRZI, drops stuffed bits and assembles bytes least significant bit first. Each completed byte is handed to an external buffer through a simple write strobe with an address.

A packet ends in one of three ways:
- A single-ended zero marks the normal end. The receiver reports completion and gives the number of whole bytes received.
- A byte arrives that would exceed the buffer. The receiver aborts with an overflow report.
- Sync never completes within a bounded number of cycles after arming. The receiver gives up with a sync-error report.

Edges seen while data is arriving move the sampling phase by one cycle at a time. This keeps the sample point near the bit centre despite a small mismatch between the clock and the bit rate. PID checks, CRC, address matching and transmission are handled elsewhere.

Top module: `ls_packet_rx`

## Requirements
- R1: While reset is held and just after it is released, `busy`, `wr_en`, `done`, `overflow` and `sync_err` are low and `byte_count` is 0.
- R2: A `start` pulse while idle raises `busy` on the next cycle and clears `byte_count`. While idle, line activity produces no strobe.
- R3: The line levels are J = {dp=0, dm=1}, K = {dp=1, dm=0} and SE0 = {dp=0, dm=0}. Sync completes only when a J-to-K edge is followed by K at two successive bit centres. A K followed by J at the next centre sends the receiver back to looking for the next J-to-K edge, with no strobe.
- R4: If sync has not completed `HUNT_LIMIT` cycles after the cycle that accepted `start`, `sync_err` pulses once and `busy` drops in that same cycle.
- R5: A data bit is 1 when the dm level at its centre equals the level at the previous centre, and 0 when it differs. The reference level for the first data bit is K.
- R6: A run of six 1s is always followed by a stuffed bit, which is discarded. The final K of sync counts as the first 1 of such a run.
- R7: Bytes are assembled with the first received bit in bit 0. Each completed byte pulses `wr_en` for one cycle with the byte on `wr_data` and addresses 0, 1, 2, … on `wr_addr`.
- R8: An SE0 at a bit centre during data pulses `done`, with `byte_count` equal to the number of whole bytes written. Trailing bits of an incomplete byte are dropped, and `busy` is low in the `done` cycle.
- R9: Exactly `BUF_BYTES` bytes end normally. If a byte completes when `BUF_BYTES` bytes are already written, that byte is not written: `overflow` pulses with `byte_count` = `BUF_BYTES` and the receiver goes idle.
- R10: A full buffer of data is received correctly when every ninth bit lasts one cycle more, or one cycle less, than `CLKS_PER_BIT`. This is about ±1% drift.
- R11: `wr_en`, `done`, `overflow` and `sync_err` are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, about CLKS_PER_BIT times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arms the receiver when idle |
| dp | input | 1 | D+ line level, already synchronised to clk |
| dm | input | 1 | D- line level, already synchronised to clk |
| busy | output | 1 | High from arming until the packet ends |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | AW | Buffer address of the byte being written |
| wr_data | output | 8 | Received byte |
| done | output | 1 | Pulse on end-of-packet |
| overflow | output | 1 | Pulse when the buffer would be exceeded |
| sync_err | output | 1 | Pulse when sync did not complete in time |
| byte_count | output | CW | Number of bytes written in this packet |

## Verification
The following properties are checked on every cycle:
- the end strobes are exclusive and each lasts a single cycle;
- `wr_addr` stays consistent with `byte_count` at every write;
- `byte_count` equals the buffer size when an overflow is reported;
- `busy` is low whenever the packet ends;
- arming always raises `busy` with a cleared count.

Other behaviour depends on the bit stream itself and can only be shown by the bench's packet scenarios:
- NRZI decoding and discarding of stuffed bits, including a run that starts in sync;
- rejection of a premature K;
- dropping of partial bytes;
- the exact cycle of the timeout;
- tolerance of a bit rate that drifts early or late.

// File: rtl/ls_packet_rx.sv
module ls_packet_rx #(
  parameter int CLKS_PER_BIT = 11,
  parameter int BUF_BYTES    = 8,
  parameter int HUNT_LIMIT   = 2048,
  localparam int AW = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1,
  localparam int CW = $clog2(BUF_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dp,
  input  logic          dm,
  output logic          busy,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          done,
  output logic          overflow,
  output logic          sync_err,
  output logic [CW-1:0] byte_count
);
  localparam int HALF = CLKS_PER_BIT / 2;
  localparam int PW   = $clog2(CLKS_PER_BIT + 1);
  localparam int TW   = $clog2(HUNT_LIMIT + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_HUNT, ST_LOCK, ST_RECV} st_t;

  st_t           st;
  logic [PW-1:0] ph, ph_nx;
  logic          dm_d, prev, lock2;
  logic [2:0]    ones, bitn;
  logic [6:0]    sr;
  logic [TW-1:0] tmo;
  logic [CW-1:0] nbytes;

  wire       is_k     = dp & ~dm;
  wire       is_se0   = ~dp & ~dm;
  wire       mid      = (ph == PW'(HALF));
  wire       edge_now = dm ^ dm_d;
  wire       bitv     = (dm == prev);
  wire       stuffed  = (ones == 3'd6);
  wire [7:0] nxt_byte = {bitv, sr};
  wire       full     = (nbytes == CW'(BUF_BYTES));
  wire       hunting  = (st == ST_HUNT) || (st == ST_LOCK);
  wire       tmo_hit  = hunting && (tmo == TW'(HUNT_LIMIT - 1));

  assign busy       = (st != ST_IDLE);
  assign byte_count = nbytes;

  always_comb begin
    ph_nx = (ph == PW'(CLKS_PER_BIT - 1)) ? '0 : ph + PW'(1);
    if (edge_now && ph != '0 && ph < PW'(HALF))
      ph_nx = ph;
    else if (edge_now && ph > PW'(HALF))
      ph_nx = (ph >= PW'(CLKS_PER_BIT - 2)) ? ph - PW'(CLKS_PER_BIT - 2) : ph + PW'(2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ph       <= '0;
      dm_d     <= 1'b1;
      prev     <= 1'b0;
      lock2    <= 1'b0;
      ones     <= '0;
      bitn     <= '0;
      sr       <= '0;
      tmo      <= '0;
      nbytes   <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      done     <= 1'b0;
      overflow <= 1'b0;
      sync_err <= 1'b0;
    end else begin
      dm_d     <= dm;
      ph       <= ph_nx;
      wr_en    <= 1'b0;
      done     <= 1'b0;
      overflow <= 1'b0;
      sync_err <= 1'b0;
      if (hunting) tmo <= tmo + TW'(1);
      case (st)
        ST_IDLE: if (start) begin
          st     <= ST_HUNT;
          tmo    <= '0;
          nbytes <= '0;
        end
        ST_HUNT: begin
          if (tmo_hit) begin
            sync_err <= 1'b1;
            st       <= ST_IDLE;
          end else if (is_k && dm_d) begin
            st    <= ST_LOCK;
            ph    <= PW'(1);
            lock2 <= 1'b0;
          end
        end
        ST_LOCK: begin
          if (tmo_hit) begin
            sync_err <= 1'b1;
            st       <= ST_IDLE;
          end else if (mid) begin
            if (!is_k) st <= ST_HUNT;
            else if (lock2) begin
              st   <= ST_RECV;
              prev <= 1'b0;
              ones <= 3'd1;
              bitn <= '0;
            end else lock2 <= 1'b1;
          end
        end
        ST_RECV: if (mid) begin
          if (is_se0) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            prev <= dm;
            if (stuffed) ones <= '0;
            else begin
              ones <= bitv ? ones + 3'd1 : 3'd0;
              sr   <= nxt_byte[7:1];
              bitn <= bitn + 3'd1;
              if (bitn == 3'd7) begin
                if (full) begin
                  overflow <= 1'b1;
                  st       <= ST_IDLE;
                end else begin
                  wr_en   <= 1'b1;
                  wr_data <= nxt_byte;
                  wr_addr <= nbytes[AW-1:0];
                  nbytes  <= nbytes + CW'(1);
                end
              end
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ls_packet_rx_chk.sv
module ls_packet_rx_chk #(
  parameter int BUF_BYTES = 8,
  parameter int AW = 3,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          done,
  input logic          overflow,
  input logic          sync_err,
  input logic [CW-1:0] byte_count
);
  assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, done, overflow, sync_err}));

  assert_write_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  assert_addr_tracks_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(byte_count) == 32'(wr_addr) + 1));

  assert_overflow_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (32'(byte_count) == BUF_BYTES));

  assert_end_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done || overflow || sync_err) |-> !busy);

  assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  assert_arm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (byte_count == '0));
endmodule

bind ls_packet_rx ls_packet_rx_chk #(.BUF_BYTES(BUF_BYTES), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .wr_en(wr_en),
  .wr_addr(wr_addr), .done(done), .overflow(overflow), .sync_err(sync_err),
  .byte_count(byte_count)
);

// File: tb/ls_packet_rx_bench.sv
module ls_packet_rx_bench;
  localparam int NB  = 8;
  localparam int LIM = 2048;
  localparam int BIT = 11;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dp = 1'b0, dm = 1'b1;
  logic busy, wr_en, done, overflow, sync_err;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [3:0] byte_count;

  always #10 clk = ~clk;

  ls_packet_rx u_ls_packet_rx (
    .clk(clk), .rst_n(rst_n), .start(start), .dp(dp), .dm(dm),
    .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .overflow(overflow), .sync_err(sync_err), .byte_count(byte_count)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, n_ev = 0, ev_cyc = 0;
  int drift = 0, bitno = 0;
  int exp_k[$];
  int exp_v[$];
  string exp_r[$];
  bit txq[$];
  int txb[$];

  always @(posedge clk) cyc++;

  task automatic chk(string req, bit ok, string what, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic expect_ev(int k, int v, string r);
    exp_k.push_back(k);
    exp_v.push_back(v);
    exp_r.push_back(r);
  endtask

  always @(negedge clk) begin : monitor
    int kind, k, v, nhi;
    string r;
    if (rst_n) begin
      nhi = int'(wr_en) + int'(done) + int'(overflow) + int'(sync_err);
      if (nhi > 1) chk("R11", 0, "strobes together", nhi, 1);
      if (nhi != 0) begin
        kind = wr_en ? 1 : done ? 2 : overflow ? 3 : 4;
        n_ev++;
        ev_cyc = cyc;
        if (exp_k.size() == 0) chk("R2", 0, "unexpected strobe kind", kind, 0);
        else begin
          k = exp_k.pop_front();
          v = exp_v.pop_front();
          r = exp_r.pop_front();
          chk(r, kind == k, "strobe kind", kind, k);
          if (kind == k && k == 1) begin
            chk(r, int'(wr_data) == (v & 255), "write data", int'(wr_data), v & 255);
            chk("R7", int'(wr_addr) == (v >> 8), "write address", int'(wr_addr), v >> 8);
          end
          if (kind == k && (k == 2 || k == 3))
            chk(r, int'(byte_count) == v, "byte count", int'(byte_count), v);
        end
      end
    end
  end

  task automatic put(logic p, logic m);
    int n;
    bitno++;
    n = (drift != 0 && bitno % 9 == 0) ? BIT + drift : BIT;
    @(negedge clk);
    dp = p;
    dm = m;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic put_j(); put(1'b0, 1'b1); endtask
  task automatic put_k(); put(1'b1, 1'b0); endtask

  task automatic build(int extra);
    txq.delete();
    foreach (txb[i]) for (int b = 0; b < 8; b++) txq.push_back(bit'((txb[i] >> b) & 1));
    for (int e = 0; e < extra; e++) txq.push_back(bit'(e & 1));
  endtask

  task automatic plan(int extra, string tag);
    int nfull;
    build(extra);
    nfull = txb.size();
    for (int i = 0; i < nfull && i < NB; i++) expect_ev(1, (i << 8) | txb[i], tag);
    if (nfull > NB) expect_ev(3, NB, "R9");
    else expect_ev(2, nfull, tag);
  endtask

  task automatic send();
    logic lv;
    int ones;
    put_k(); put_j(); put_k(); put_j(); put_k(); put_j(); put_k(); put_k();
    lv = 1'b0;
    ones = 1;
    foreach (txq[i]) begin
      if (!txq[i]) lv = ~lv;
      put(~lv, lv);
      if (txq[i]) begin
        ones++;
        if (ones == 6) begin
          lv = ~lv;
          put(~lv, lv);
          ones = 0;
        end
      end else ones = 0;
    end
    put(1'b0, 1'b0); put(1'b0, 1'b0); put_j();
  endtask

  task automatic start_rx();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2", busy == 1'b1, "busy after start", int'(busy), 1);
    chk("R2", byte_count == 4'd0, "count after start", int'(byte_count), 0);
    put_j(); put_j();
  endtask

  task automatic settle(string r);
    repeat (40) @(negedge clk);
    chk(r, exp_k.size() == 0, "events still owed", exp_k.size(), 0);
    chk(r, busy == 1'b0, "busy after packet", int'(busy), 0);
    exp_k.delete(); exp_v.delete(); exp_r.delete();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk("R1", 0, "watchdog expired", cyc, 0);
    summary();
    $finish;
  end

  initial begin : main
    int t0, ev0;
    repeat (4) @(negedge clk);
    // R1 during and after reset
    chk("R1", !busy && !wr_en && !done && !overflow && !sync_err, "strobes in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", !busy && !wr_en && !done && !overflow && !sync_err, "strobes after reset", int'(busy), 0);
    chk("R1", byte_count == 4'd0, "count after reset", int'(byte_count), 0);

    // R2: not armed, line activity ignored
    ev0 = n_ev;
    txb = '{8'h12, 8'h34};
    build(0);
    put_j(); send();
    repeat (40) @(negedge clk);
    chk("R2", n_ev == ev0, "strobes while idle", n_ev - ev0, 0);
    chk("R2", busy == 1'b0, "busy while idle", int'(busy), 0);

    // R5 R7 R8: plain packet with both transition-rich and flat bytes
    txb = '{8'hA5, 8'h3C, 8'h00};
    start_rx(); plan(0, "R5"); send(); settle("R5");

    // R6: long runs of ones, including one started by sync
    txb = '{8'hFF, 8'hFF, 8'h7E, 8'h3F};
    start_rx(); plan(0, "R6"); send(); settle("R6");

    // R3: stray K before the real sync
    txb = '{8'h5A, 8'hC1};
    start_rx(); put_k(); put_j(); put_j(); put_j();
    plan(0, "R3"); send(); settle("R3");

    // R8: partial trailing byte dropped
    txb = '{8'hC3, 8'h81};
    start_rx(); plan(3, "R8"); send(); settle("R8");

    // R8: empty packet
    txb.delete();
    start_rx(); plan(0, "R8"); send(); settle("R8");

    // R9: exactly full buffer ends normally
    txb = '{8'h01, 8'h23, 8'h45, 8'h67, 8'h89, 8'hAB, 8'hCD, 8'hEF};
    start_rx(); plan(0, "R9"); send(); settle("R9");

    // R9: overflow
    txb = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99, 8'hAA};
    start_rx(); plan(0, "R9"); send(); settle("R9");

    // R10: slow then fast bit rate
    txb = '{8'h5A, 8'hE7, 8'h0F, 8'hF0, 8'hB6, 8'h49, 8'hFE, 8'h13};
    drift = 1; bitno = 0;
    start_rx(); plan(0, "R10"); send(); settle("R10");
    txb = '{8'hC9, 8'h36, 8'hFF, 8'h80, 8'h7F, 8'h2D, 8'hD2, 8'h55};
    drift = -1; bitno = 0;
    start_rx(); plan(0, "R10"); send(); settle("R10");
    drift = 0;

    // R4: timeout on a silent bus
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    t0 = cyc;
    expect_ev(4, 0, "R4");
    repeat (LIM + 10) @(negedge clk);
    chk("R4", ev_cyc - t0 == LIM, "timeout cycle", ev_cyc - t0, LIM);
    settle("R4");

    summary();
    $finish;
  end
endmodule